// File: doc/BRIEF.md
# Interrupt Coalescing Timer

This block reduces the interrupt rate of a 10/100 Mbps Ethernet controller by merging per-packet completion pulses into a smaller number of status events. It has two identical engines, one for the transmit direction and one for the receive direction. Each engine counts completion pulses. It raises its status bit when the count reaches a programmed threshold, or when a programmed number of base cycles has passed since the first pulse still pending, whichever comes first.

A base cycle is 512 bit times, or 8192 bit times when the long-cycle bit is set. The timer is clocked by a bit-time tick that runs at the 100 Mbps bit rate. When the link runs at 10 Mbps, the block divides that tick by ten, so a base cycle lasts 5.12 us or 81.92 us at 100 Mbps and 51.2 us or 819.2 us at 10 Mbps. The timer does not depend on the system clock frequency. A status bit stays set until software clears it. A clear that arrives in the same cycle as a new trigger loses to the trigger.

Top module: `intr_coalesce`

## Requirements
- R1: After reset, both `tx_irq_o` and `rx_irq_o` are 0.
- R2: With a threshold field of n (1 to 7) and the timer disabled, the status bit of that direction rises in the cycle after its n-th completion pulse is sampled, and not earlier.
- R3: A threshold field of 0 behaves like 1, so a single pulse sets the status bit in the next cycle.
- R4: With a timeout field t > 0, normal cycle and `link_fast_i` = 1, the status bit rises exactly t*512 sampled ticks after the first pending pulse, provided the threshold has not been reached.
- R5: With the long-cycle bit set, each timeout unit is 8192 sampled ticks.
- R6: With `link_fast_i` = 0, each timeout unit lasts ten times as many ticks (5120 for a normal cycle).
- R7: A timeout field of 0 disables the timer, so only the threshold can set the status bit, however long the engine waits.
- R8: The timer runs only while at least one pulse is pending. Whenever the status is raised, the pulse count and the timer restart, and the timer starts again from zero on the next first pulse.
- R9: A status bit stays set until its clear input is sampled. The clear drops the bit in the next cycle, except that a trigger in the same cycle keeps the bit set.
- R10: The two directions are independent. The control word places the transmit fields at bit 15 (long cycle), bits 14:12 (threshold) and bits 11:8 (timeout), and the receive fields at bit 7, bits 6:4 and bits 3:0.
- R11: The timer advances only in cycles where `bit_tick_i` is 1. While the tick is held low, a pending timeout does not expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 16 | Coalescing control word (field layout in R10) |
| link_fast_i | input | 1 | 1 = 100 Mbps link, 0 = 10 Mbps link |
| bit_tick_i | input | 1 | One-cycle pulse per 100 Mbps bit time |
| tx_done_i | input | 1 | Transmit completion pulse |
| rx_done_i | input | 1 | Receive completion pulse |
| tx_clr_i | input | 1 | Software clear of the transmit status bit |
| rx_clr_i | input | 1 | Software clear of the receive status bit |
| tx_irq_o | output | 1 | Coalesced transmit status bit |
| rx_irq_o | output | 1 | Coalesced receive status bit |

## Verification
The hardest case to reach from the ports is a timeout that expires exactly on a base-cycle boundary while the ten-to-one prescaler or a long cycle is in use. An off-by-one error there shows only in the cycle-exact position of the rising status bit. The stimulus holds the tick high, issues a single pulse with the threshold set to 7, and counts clock edges. It samples one edge before and one edge at the expected expiry. A second awkward case is restarting the timer after a threshold hit. The bench raises the status through the threshold halfway through a timeout window, waits well beyond that window to show that nothing fires, and then times a fresh pulse from zero.

// File: rtl/icoal_pkg.sv
package icoal_pkg;
   localparam int THR_W   = 3;
   localparam int TMO_W   = 4;
   localparam int FIELD_W = 1 + THR_W + TMO_W;
   localparam int CTRL_W  = 2 * FIELD_W;

   typedef struct packed {
      logic             long_cyc;
      logic [THR_W-1:0] thr;
      logic [TMO_W-1:0] tmo;
   } dir_cfg_t;
endpackage

// File: rtl/icoal_tick_scaler.sv
module icoal_tick_scaler #(
   parameter int DIV = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic slow_i,
   input  logic run_i,
   input  logic restart_i,
   output logic tick_o
);
   if (DIV < 1) begin : g_bad_div
      $error("icoal_tick_scaler: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick_o = tick_i;
   end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni || restart_i) begin
            pre_q <= '0;
         end else if (run_i && tick_i && slow_i) begin
            pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
         end
      end

      assign tick_o = tick_i && (!slow_i || pre_q == LAST);

      assert_pre_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pre_q <= LAST);
   end
endmodule

// File: rtl/icoal_engine.sv
module icoal_engine #(
   parameter int NORM_BITS = 512,
   parameter int LONG_BITS = 8192,
   parameter int SLOW_DIV  = 10
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  icoal_pkg::dir_cfg_t   cfg_i,
   input  logic                  fast_i,
   input  logic                  tick_i,
   input  logic                  evt_i,
   input  logic                  clr_i,
   output logic                  irq_o
);
   import icoal_pkg::*;

   localparam int BIT_W = $clog2(LONG_BITS);

   if (NORM_BITS < 2 || LONG_BITS <= NORM_BITS) begin : g_bad_len
      $error("icoal_engine: need 2 <= NORM_BITS < LONG_BITS");
   end

   logic [THR_W-1:0] cnt_q;
   logic [BIT_W-1:0] bit_cnt_q;
   logic [TMO_W-1:0] cyc_cnt_q;
   logic             irq_q;

   logic             pending, base_tick, wrap, thr_hit, tmo_hit, fire, start;
   logic [THR_W-1:0] thr_eff;
   logic [TMO_W-1:0] tmo_m1;
   logic [BIT_W-1:0] cyc_last;
   logic [THR_W:0]   cnt_inc;

   icoal_tick_scaler #(.DIV(SLOW_DIV)) i_scaler (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .slow_i   (!fast_i),
      .run_i    (pending),
      .restart_i(fire || start),
      .tick_o   (base_tick)
   );

   always_comb begin
      pending  = (cnt_q != '0);
      thr_eff  = (cfg_i.thr == '0) ? THR_W'(1) : cfg_i.thr;
      tmo_m1   = cfg_i.tmo - TMO_W'(1);
      cyc_last = cfg_i.long_cyc ? BIT_W'(LONG_BITS - 1) : BIT_W'(NORM_BITS - 1);
      cnt_inc  = {1'b0, cnt_q} + (THR_W+1)'(1);
      wrap     = base_tick && (bit_cnt_q >= cyc_last);
      thr_hit  = evt_i && (cnt_inc >= {1'b0, thr_eff});
      tmo_hit  = pending && (cfg_i.tmo != '0) && wrap && (cyc_cnt_q == tmo_m1);
      fire     = thr_hit || tmo_hit;
      start    = evt_i && !pending && !fire;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q     <= '0;
         bit_cnt_q <= '0;
         cyc_cnt_q <= '0;
      end else if (fire) begin
         cnt_q     <= '0;
         bit_cnt_q <= '0;
         cyc_cnt_q <= '0;
      end else if (start) begin
         cnt_q     <= THR_W'(1);
         bit_cnt_q <= '0;
         cyc_cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + THR_W'(evt_i);
         if (pending && base_tick) begin
            if (wrap) begin
               bit_cnt_q <= '0;
               cyc_cnt_q <= cyc_cnt_q + TMO_W'(1);
            end else begin
               bit_cnt_q <= bit_cnt_q + BIT_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     irq_q <= 1'b0;
      else if (fire)   irq_q <= 1'b1;
      else if (clr_i)  irq_q <= 1'b0;
   end

   assign irq_o = irq_q;

   assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q && !clr_i |=> irq_q);

   assert_clear_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i && !evt_i && !tick_i |=> !irq_q);

   assert_single_evt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i && (cfg_i.thr <= THR_W'(1)) |=> irq_q);

   assert_timer_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q == '0 |-> bit_cnt_q == '0 && cyc_cnt_q == '0);

   assert_tick_gates_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i && !evt_i |=> $stable(bit_cnt_q) && $stable(cyc_cnt_q));

   assert_tmo_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_i.tmo == '0 && !evt_i |=> !$rose(irq_q));
endmodule

// File: rtl/intr_coalesce.sv
module intr_coalesce #(
   parameter int NORM_BITS = 512,
   parameter int LONG_BITS = 8192,
   parameter int SLOW_DIV  = 10
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [icoal_pkg::CTRL_W-1:0] ctrl_i,
   input  logic                        link_fast_i,
   input  logic                        bit_tick_i,
   input  logic                        tx_done_i,
   input  logic                        rx_done_i,
   input  logic                        tx_clr_i,
   input  logic                        rx_clr_i,
   output logic                        tx_irq_o,
   output logic                        rx_irq_o
);
   import icoal_pkg::*;

   localparam int N_DIR = 2;

   logic [N_DIR-1:0] evt_vec, clr_vec, irq_vec;

   assign evt_vec = {tx_done_i, rx_done_i};
   assign clr_vec = {tx_clr_i, rx_clr_i};

   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      dir_cfg_t cfg;
      assign cfg = dir_cfg_t'(ctrl_i[d*FIELD_W +: FIELD_W]);

      icoal_engine #(
         .NORM_BITS(NORM_BITS),
         .LONG_BITS(LONG_BITS),
         .SLOW_DIV (SLOW_DIV)
      ) i_engine (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .cfg_i (cfg),
         .fast_i(link_fast_i),
         .tick_i(bit_tick_i),
         .evt_i (evt_vec[d]),
         .clr_i (clr_vec[d]),
         .irq_o (irq_vec[d])
      );
   end

   assign rx_irq_o = irq_vec[0];
   assign tx_irq_o = irq_vec[1];

   assert_dir_indep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tx_done_i && !tx_irq_o && !bit_tick_i |=> !tx_irq_o);
endmodule

// File: tb/test_intr_coalesce.sv
`timescale 1ns/1ps
module test_intr_coalesce;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ctrl = 16'h0000;
   logic        fast = 1'b1;
   logic        tick = 1'b1;
   logic        tx_done = 1'b0, rx_done = 1'b0, tx_clr = 1'b0, rx_clr = 1'b0;
   logic        tx_irq, rx_irq;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   intr_coalesce i_intr_coalesce (
      .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .link_fast_i(fast),
      .bit_tick_i(tick), .tx_done_i(tx_done), .rx_done_i(rx_done),
      .tx_clr_i(tx_clr), .rx_clr_i(rx_clr), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
   );

   task automatic check(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic pulse(logic t, logic r, logic ct, logic cr);
      tx_done = t; rx_done = r; tx_clr = ct; rx_clr = cr;
      @(negedge clk);
      tx_done = 1'b0; rx_done = 1'b0; tx_clr = 1'b0; rx_clr = 1'b0;
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 tx after reset", tx_irq, 1'b0);
      check("R1 rx after reset", rx_irq, 1'b0);
   endtask

   task automatic t_threshold;
      ctrl = 16'h3010;
      pulse(1, 0, 0, 0);
      pulse(1, 0, 0, 0);
      check("R2 tx before 3rd event", tx_irq, 1'b0);
      pulse(1, 0, 0, 0);
      check("R2 tx at 3rd event", tx_irq, 1'b1);
      check("R10 rx untouched by tx", rx_irq, 1'b0);
      pulse(0, 1, 0, 0);
      check("R10 rx own threshold", rx_irq, 1'b1);
      pulse(0, 0, 1, 1);
      check("R9 tx cleared", tx_irq, 1'b0);
      check("R9 rx cleared", rx_irq, 1'b0);
   endtask

   task automatic t_thr_zero;
      ctrl = 16'h0000;
      pulse(0, 1, 0, 0);
      check("R3 zero threshold acts as one", rx_irq, 1'b1);
      pulse(0, 0, 0, 1);
   endtask

   task automatic t_timeout_norm;
      ctrl = 16'h0072;
      pulse(0, 1, 0, 0);
      wait_n(1023);
      check("R4 one tick before 2x512", rx_irq, 1'b0);
      wait_n(1);
      check("R4 at 2x512 ticks", rx_irq, 1'b1);
      check("R10 tx unaffected by rx timer", tx_irq, 1'b0);
      pulse(0, 0, 0, 1);
   endtask

   task automatic t_long;
      ctrl = 16'hF100;
      pulse(1, 0, 0, 0);
      wait_n(8191);
      check("R5 one tick before 8192", tx_irq, 1'b0);
      wait_n(1);
      check("R5 at 8192 ticks", tx_irq, 1'b1);
      pulse(0, 0, 1, 0);
   endtask

   task automatic t_slow;
      ctrl = 16'h0071;
      fast = 1'b0;
      pulse(0, 1, 0, 0);
      wait_n(5119);
      check("R6 one tick before 5120", rx_irq, 1'b0);
      wait_n(1);
      check("R6 at 5120 ticks", rx_irq, 1'b1);
      fast = 1'b1;
      pulse(0, 0, 0, 1);
   endtask

   task automatic t_tmo_off;
      ctrl = 16'h0070;
      pulse(0, 1, 0, 0);
      wait_n(20000);
      check("R7 no timeout when field is 0", rx_irq, 1'b0);
      for (int i = 0; i < 6; i++) pulse(0, 1, 0, 0);
      check("R7 threshold still fires", rx_irq, 1'b1);
      pulse(0, 0, 0, 1);
   endtask

   task automatic t_restart;
      ctrl = 16'h0021;
      wait_n(2000);
      check("R8 no fire while nothing pending", rx_irq, 1'b0);
      pulse(0, 1, 0, 0);
      wait_n(300);
      pulse(0, 1, 0, 0);
      check("R8 threshold hit mid window", rx_irq, 1'b1);
      pulse(0, 0, 0, 1);
      wait_n(1000);
      check("R8 old window discarded", rx_irq, 1'b0);
      pulse(0, 1, 0, 0);
      wait_n(511);
      check("R8 fresh window not yet over", rx_irq, 1'b0);
      wait_n(1);
      check("R8 fresh window at 512", rx_irq, 1'b1);
      pulse(0, 0, 0, 1);
   endtask

   task automatic t_sticky;
      ctrl = 16'h0000;
      pulse(0, 1, 0, 0);
      wait_n(50);
      check("R9 bit holds until clear", rx_irq, 1'b1);
      pulse(0, 0, 0, 1);
      check("R9 clear drops bit", rx_irq, 1'b0);
      pulse(0, 1, 0, 1);
      check("R9 trigger beats clear", rx_irq, 1'b1);
      pulse(0, 0, 0, 1);
   endtask

   task automatic t_tick;
      ctrl = 16'h0071;
      tick = 1'b0;
      pulse(0, 1, 0, 0);
      wait_n(6000);
      check("R11 no expiry without ticks", rx_irq, 1'b0);
      tick = 1'b1;
      wait_n(511);
      check("R11 one tick short", rx_irq, 1'b0);
      wait_n(1);
      check("R11 expiry after 512 ticks", rx_irq, 1'b1);
      pulse(0, 0, 0, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_threshold();
      t_thr_zero();
      t_timeout_norm();
      t_long();
      t_slow();
      t_tmo_off();
      t_restart();
      t_sticky();
      t_tick();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule